// File: doc/BRIEF.md
# PCI Configuration Cycle Router

This block takes configuration accesses and decides, in one registered step, where each one goes. An access can come straight from a memory-mapped aperture. It can also come through the indirect I/O pair: a full-dword write to an address register whose top bit enables the mechanism, followed by a read or write to a data register. Every access ends up with exactly one destination:

- a claim by one of the five internal devices on bus 0;
- a Type 0 or Type 1 cycle to one of three downstream bridge ports;
- a Type 0 or Type 1 cycle on the default downstream link.

For bus 0, the block applies a claim rule for each internal device. Anything on bus 0 that no device claims falls through to the default link as Type 0. For a nonzero bus, the block compares the bus number against the secondary and subordinate bus numbers of each port. All three equality tests take precedence over any range test, and among equal candidates the lowest port index wins. A nonzero bus that matches nothing goes to the default link as Type 1. Completion data, the contents of the port registers and the link protocols lie outside this block. The port bus numbers and the device enables arrive as plain inputs.

Top module: `cfg_router`

## Requirements
- R1: A write to the address register (`io_sel_data_i`=0) with `io_dword_i`=1 stores bit 31 and bits 23:2 of `io_wdata_i`. Bits 30:24 and 1:0 are stored as zero. A write with `io_dword_i`=0 is ignored. A read of the address register raises `io_rvalid_o` for one cycle, one cycle after the read, with `io_rdata_o` equal to the stored value. When `io_rvalid_o` is low, `io_rdata_o` is zero.
- R2: A data-register access (`io_sel_data_i`=1) while stored bit 31 is 1 produces `route_valid_o`=1 one cycle later. The route carries bus = stored bits 23:16, device = bits 15:11, function = bits 10:8, register = bits 7:2, and `route_write_o` = `io_write_i`.
- R3: A data-register access while stored bit 31 is 0 produces no route. A read of this kind returns all ones on `io_rdata_o` with `io_rvalid_o`, one cycle later. A write of this kind is discarded.
- R4: An aperture access (`mem_valid_i`) is routed one cycle later from the `mem_*` fields, with no address-register step. If an enabled data-register access arrives in the same cycle, the aperture access is routed and the I/O access is dropped.
- R5: On bus 0, device 0 is claimed when the function is 0, or when the function is 1 and `fn1_en_i` is 1.
- R6: On bus 0, device d (1 to 4) is claimed only when the function is 0 and `dev_en_i[d-1]` is 1.
- R7: An access on bus 0 that no device claims goes to the default link as Type 0. A bus-0 access never selects a port and never goes out as Type 1.
- R8: A nonzero bus equal to the secondary bus of port p (`port_sec_i[8p+7:8p]`) gives a Type 0 cycle to port p. The lowest such p wins, and an equality match at any port beats a range match at every port.
- R9: Failing any equality match, if secondary < bus <= subordinate (`port_sub_i[8p+7:8p]`) for port p, the result is a Type 1 cycle to that port. The lowest such p wins.
- R10: A nonzero bus with neither an equality match nor a range match goes to the default link as Type 1.
- R11: `route_onehot_o` uses bit 0 for internal claim, bit 1 for port Type 0, bit 2 for port Type 1, bit 3 for link Type 0 and bit 4 for link Type 1. Exactly one bit is set while `route_valid_o` is 1, and all bits are 0 otherwise. `route_port_o` holds the port index for port routes and 0 otherwise. `route_type1_o` is 1 exactly for bits 2 and 4.
- R12: While reset is asserted, every output is zero and the address register is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| io_valid_i | input | 1 | I/O access this cycle |
| io_write_i | input | 1 | I/O access is a write |
| io_sel_data_i | input | 1 | 1 = data register, 0 = address register |
| io_dword_i | input | 1 | write covers the full dword |
| io_wdata_i | input | 32 | I/O write data |
| io_rvalid_o | output | 1 | I/O read data valid |
| io_rdata_o | output | 32 | I/O read data |
| mem_valid_i | input | 1 | aperture access this cycle |
| mem_write_i | input | 1 | aperture access is a write |
| mem_bus_i | input | 8 | aperture bus number |
| mem_dev_i | input | 5 | aperture device number |
| mem_fn_i | input | 3 | aperture function number |
| mem_reg_i | input | 6 | aperture dword register index |
| fn1_en_i | input | 1 | device 0 function 1 enabled |
| dev_en_i | input | 4 | enables for internal devices 1..4 |
| port_sec_i | input | 24 | secondary bus numbers, 8 bits per port |
| port_sub_i | input | 24 | subordinate bus numbers, 8 bits per port |
| route_valid_o | output | 1 | one-cycle routing strobe |
| route_onehot_o | output | 5 | destination, one-hot |
| route_port_o | output | 2 | selected port index |
| route_type1_o | output | 1 | cycle is Type 1 |
| route_bus_o | output | 8 | routed bus number |
| route_dev_o | output | 5 | routed device number |
| route_fn_o | output | 3 | routed function number |
| route_reg_o | output | 6 | routed register index |
| route_write_o | output | 1 | routed access is a write |

## Verification
Every result of this block is due exactly one clock edge after the access that causes it. This holds for the route strobe and its fields, for the all-ones answer to a disabled data read, and for an address-register read-back. An address-register write changes the outcome of the next data access, not the current one. The bench drives one access per cycle on the falling edge and updates a behavioural model of the address register and the routing rules at that moment. It then compares every output at the following falling edge, one rising edge later. This applies to idle cycles as well, so a late, early or extra strobe shows up as a miscompare.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
  parameter int unsigned BUS_W = 8;
  parameter int unsigned DEV_W = 5;
  parameter int unsigned FN_W  = 3;
  parameter int unsigned REG_W = 6;
  localparam int unsigned ROUTE_N = 5;
  localparam logic [31:0] ADDR_KEEP = 32'h80FF_FFFC;

  typedef enum logic [2:0] {
    RT_CLAIM   = 3'd0,
    RT_PORT_T0 = 3'd1,
    RT_PORT_T1 = 3'd2,
    RT_LINK_T0 = 3'd3,
    RT_LINK_T1 = 3'd4
  } route_e;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] regn;
    logic             wr;
  } cfg_req_t;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_router_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        io_valid_i,
  input  logic        io_write_i,
  input  logic        io_sel_data_i,
  input  logic        io_dword_i,
  input  logic [31:0] io_wdata_i,
  input  logic        mem_valid_i,
  output logic        ind_valid_o,
  output cfg_req_t    ind_req_o,
  output logic        io_rvalid_o,
  output logic [31:0] io_rdata_o
);
  logic [31:0] addr_q;
  logic        addr_wr, data_acc, rd_addr, rd_dis;

  assign addr_wr  = io_valid_i && io_write_i && !io_sel_data_i && io_dword_i;
  assign data_acc = io_valid_i && io_sel_data_i;
  assign rd_addr  = io_valid_i && !io_write_i && !io_sel_data_i;
  assign rd_dis   = data_acc && !io_write_i && !addr_q[31];

  // aperture wins a same-cycle collision
  assign ind_valid_o    = data_acc && addr_q[31] && !mem_valid_i;
  assign ind_req_o.bus  = addr_q[23:16];
  assign ind_req_o.dev  = addr_q[15:11];
  assign ind_req_o.fn   = addr_q[10:8];
  assign ind_req_o.regn = addr_q[7:2];
  assign ind_req_o.wr   = io_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      io_rvalid_o <= 1'b0;
      io_rdata_o  <= '0;
    end else begin
      if (addr_wr) addr_q <= io_wdata_i & ADDR_KEEP;
      io_rvalid_o <= rd_addr || rd_dis;
      io_rdata_o  <= rd_addr ? addr_q : (rd_dis ? '1 : '0);
    end
  end

  AST_DIS_READ_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_i && io_sel_data_i && !io_write_i && !addr_q[31] |=> io_rvalid_o && io_rdata_o == '1); // R3
  AST_ADDR_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_i && !io_write_i && !io_sel_data_i |=> io_rvalid_o && io_rdata_o[1:0] == 2'b00 && io_rdata_o[30:24] == '0); // R1
  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rvalid_o |-> io_rdata_o == '0); // R1
endmodule

// File: rtl/cfg_port_match.sv
module cfg_port_match
  import cfg_router_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3
) (
  input  logic [BUS_W-1:0]           bus_i,
  input  logic [NUM_PORTS*BUS_W-1:0] sec_i,
  input  logic [NUM_PORTS*BUS_W-1:0] sub_i,
  output logic [NUM_PORTS-1:0]       eq_o,
  output logic [NUM_PORTS-1:0]       rng_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [BUS_W-1:0] sec, sub;
    assign sec      = sec_i[p*BUS_W +: BUS_W];
    assign sub      = sub_i[p*BUS_W +: BUS_W];
    assign eq_o[p]  = bus_i == sec;
    assign rng_o[p] = (bus_i > sec) && (bus_i <= sub);
  end
endmodule

// File: rtl/cfg_route_dec.sv
module cfg_route_dec
  import cfg_router_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 3,
  parameter int unsigned NUM_INT_DEV = 5,
  parameter int unsigned PORT_IW     = 2
) (
  input  logic [BUS_W-1:0]       bus_i,
  input  logic [DEV_W-1:0]       dev_i,
  input  logic [FN_W-1:0]        fn_i,
  input  logic                   fn1_en_i,
  input  logic [NUM_INT_DEV-2:0] dev_en_i,
  input  logic [NUM_PORTS-1:0]   eq_i,
  input  logic [NUM_PORTS-1:0]   rng_i,
  output logic [ROUTE_N-1:0]     route_o,
  output logic [PORT_IW-1:0]     port_o
);
  logic               claim, eq_hit, rng_hit;
  logic [PORT_IW-1:0] eq_idx, rng_idx;

  always_comb begin
    claim = 1'b0;
    if (dev_i == '0) claim = (fn_i == '0) || (fn_i == FN_W'(1) && fn1_en_i);
    for (int d = 1; d < NUM_INT_DEV; d++)
      if (dev_i == DEV_W'(d) && fn_i == '0 && dev_en_i[d-1]) claim = 1'b1;
  end

  // descending scan: lowest index is assigned last and wins
  always_comb begin
    eq_hit = 1'b0; rng_hit = 1'b0; eq_idx = '0; rng_idx = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (eq_i[p])  begin eq_hit  = 1'b1; eq_idx  = PORT_IW'(p); end
      if (rng_i[p]) begin rng_hit = 1'b1; rng_idx = PORT_IW'(p); end
    end
  end

  always_comb begin
    route_o = '0;
    port_o  = '0;
    if (bus_i == '0) begin
      if (claim) route_o[RT_CLAIM]   = 1'b1;
      else       route_o[RT_LINK_T0] = 1'b1;
    end else if (eq_hit) begin
      route_o[RT_PORT_T0] = 1'b1;
      port_o              = eq_idx;
    end else if (rng_hit) begin
      route_o[RT_PORT_T1] = 1'b1;
      port_o              = rng_idx;
    end else begin
      route_o[RT_LINK_T1] = 1'b1;
    end
  end
endmodule

// File: rtl/cfg_router.sv
module cfg_router
  import cfg_router_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 3,
  parameter int unsigned NUM_INT_DEV = 5,
  localparam int unsigned PORT_IW    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       io_valid_i,
  input  logic                       io_write_i,
  input  logic                       io_sel_data_i,
  input  logic                       io_dword_i,
  input  logic [31:0]                io_wdata_i,
  output logic                       io_rvalid_o,
  output logic [31:0]                io_rdata_o,
  input  logic                       mem_valid_i,
  input  logic                       mem_write_i,
  input  logic [BUS_W-1:0]           mem_bus_i,
  input  logic [DEV_W-1:0]           mem_dev_i,
  input  logic [FN_W-1:0]            mem_fn_i,
  input  logic [REG_W-1:0]           mem_reg_i,
  input  logic                       fn1_en_i,
  input  logic [NUM_INT_DEV-2:0]     dev_en_i,
  input  logic [NUM_PORTS*BUS_W-1:0] port_sec_i,
  input  logic [NUM_PORTS*BUS_W-1:0] port_sub_i,
  output logic                       route_valid_o,
  output logic [ROUTE_N-1:0]         route_onehot_o,
  output logic [PORT_IW-1:0]         route_port_o,
  output logic                       route_type1_o,
  output logic [BUS_W-1:0]           route_bus_o,
  output logic [DEV_W-1:0]           route_dev_o,
  output logic [FN_W-1:0]            route_fn_o,
  output logic [REG_W-1:0]           route_reg_o,
  output logic                       route_write_o
);
  cfg_req_t               ind_req, mem_req, req;
  logic                   ind_valid, req_v;
  logic [NUM_PORTS-1:0]   eq_vec, rng_vec;
  logic [ROUTE_N-1:0]     dec_route;
  logic [PORT_IW-1:0]     dec_port;

  cfg_addr_reg u_addr (
    .clk_i, .rst_ni, .io_valid_i, .io_write_i, .io_sel_data_i, .io_dword_i,
    .io_wdata_i, .mem_valid_i,
    .ind_valid_o (ind_valid),
    .ind_req_o   (ind_req),
    .io_rvalid_o, .io_rdata_o
  );

  assign mem_req = '{bus: mem_bus_i, dev: mem_dev_i, fn: mem_fn_i,
                     regn: mem_reg_i, wr: mem_write_i};
  assign req_v   = mem_valid_i || ind_valid;
  assign req     = mem_valid_i ? mem_req : ind_req;

  cfg_port_match #(.NUM_PORTS(NUM_PORTS)) u_match (
    .bus_i (req.bus), .sec_i (port_sec_i), .sub_i (port_sub_i),
    .eq_o  (eq_vec),  .rng_o (rng_vec)
  );

  cfg_route_dec #(.NUM_PORTS(NUM_PORTS), .NUM_INT_DEV(NUM_INT_DEV), .PORT_IW(PORT_IW)) u_dec (
    .bus_i (req.bus), .dev_i (req.dev), .fn_i (req.fn),
    .fn1_en_i, .dev_en_i,
    .eq_i (eq_vec), .rng_i (rng_vec),
    .route_o (dec_route), .port_o (dec_port)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_valid_o  <= 1'b0;
      route_onehot_o <= '0;
      route_port_o   <= '0;
      route_type1_o  <= 1'b0;
      route_bus_o    <= '0;
      route_dev_o    <= '0;
      route_fn_o     <= '0;
      route_reg_o    <= '0;
      route_write_o  <= 1'b0;
    end else begin
      route_valid_o  <= req_v;
      route_onehot_o <= req_v ? dec_route : '0;
      route_port_o   <= req_v ? dec_port : '0;
      route_type1_o  <= req_v && (dec_route[RT_PORT_T1] || dec_route[RT_LINK_T1]);
      if (req_v) begin
        route_bus_o   <= req.bus;
        route_dev_o   <= req.dev;
        route_fn_o    <= req.fn;
        route_reg_o   <= req.regn;
        route_write_o <= req.wr;
      end
    end
  end

  AST_ONE_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_valid_o |-> $countones(route_onehot_o) == 1); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_valid_o |-> route_onehot_o == '0 && route_port_o == '0 && !route_type1_o); // R11
  AST_MEM_ROUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i |=> route_valid_o && route_bus_o == $past(mem_bus_i)); // R4
  AST_BUS0_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_v && req.bus == '0 |=> (route_onehot_o[RT_CLAIM] || route_onehot_o[RT_LINK_T0]) && !route_type1_o); // R7
  AST_PORT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_valid_o |-> int'(route_port_o) < NUM_PORTS); // R11
endmodule

// File: tb/cfg_router_tb.sv
`timescale 1ns/1ps
module cfg_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 0, io_write = 0, io_sel = 0, io_dword = 0;
  logic [31:0] io_wdata = '0;
  logic        io_rvalid;
  logic [31:0] io_rdata;
  logic        mem_valid = 0, mem_write = 0;
  logic [7:0]  mem_bus = '0;
  logic [4:0]  mem_dev = '0;
  logic [2:0]  mem_fn = '0;
  logic [5:0]  mem_reg = '0;
  logic        fn1_en = 0;
  logic [3:0]  dev_en = '0;
  logic [23:0] port_sec = '0, port_sub = '0;
  logic        r_valid, r_t1, r_write;
  logic [4:0]  r_oh, r_dev;
  logic [1:0]  r_port;
  logic [7:0]  r_bus;
  logic [2:0]  r_fn;
  logic [5:0]  r_reg;

  int vectors = 0, miscompares = 0;
  logic [31:0] m_addr = '0;
  logic        exp_v, exp_rv, exp_t1, exp_w;
  logic [4:0]  exp_oh;
  int          exp_port, exp_bus, exp_dev, exp_fn, exp_reg;
  logic [31:0] exp_rd;
  string       vtag, rtag, rdtag;

  always #10 clk = ~clk;

  cfg_router dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .io_valid_i(io_valid), .io_write_i(io_write), .io_sel_data_i(io_sel),
    .io_dword_i(io_dword), .io_wdata_i(io_wdata),
    .io_rvalid_o(io_rvalid), .io_rdata_o(io_rdata),
    .mem_valid_i(mem_valid), .mem_write_i(mem_write), .mem_bus_i(mem_bus),
    .mem_dev_i(mem_dev), .mem_fn_i(mem_fn), .mem_reg_i(mem_reg),
    .fn1_en_i(fn1_en), .dev_en_i(dev_en),
    .port_sec_i(port_sec), .port_sub_i(port_sub),
    .route_valid_o(r_valid), .route_onehot_o(r_oh), .route_port_o(r_port),
    .route_type1_o(r_t1), .route_bus_o(r_bus), .route_dev_o(r_dev),
    .route_fn_o(r_fn), .route_reg_o(r_reg), .route_write_o(r_write)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic route_model(int bus, int dev, int fn);
    int sec, sub;
    exp_port = 0;
    if (bus == 0) begin
      if ((dev == 0 && (fn == 0 || (fn == 1 && fn1_en))) ||
          (dev >= 1 && dev <= 4 && fn == 0 && dev_en[dev-1])) begin
        exp_oh = 5'b00001; rtag = (dev == 0) ? "R5" : "R6";
      end else begin
        exp_oh = 5'b01000; rtag = "R7";
      end
      return;
    end
    for (int p = 0; p < 3; p++) begin
      sec = int'(port_sec[p*8 +: 8]);
      if (bus == sec) begin exp_oh = 5'b00010; exp_port = p; rtag = "R8"; return; end
    end
    for (int p = 0; p < 3; p++) begin
      sec = int'(port_sec[p*8 +: 8]);
      sub = int'(port_sub[p*8 +: 8]);
      if (bus > sec && bus <= sub) begin exp_oh = 5'b00100; exp_port = p; rtag = "R9"; return; end
    end
    exp_oh = 5'b10000; rtag = "R10";
  endtask

  task automatic model();
    exp_v = 0; exp_oh = '0; exp_port = 0; exp_t1 = 0; exp_rv = 0; exp_rd = '0;
    vtag = "R11"; rtag = "R11"; rdtag = "R1";
    if (io_valid && !io_write) begin
      if (!io_sel) begin exp_rv = 1; exp_rd = m_addr; end
      else if (!m_addr[31]) begin exp_rv = 1; exp_rd = '1; rdtag = "R3"; end
    end
    if (io_valid && io_sel && !m_addr[31]) vtag = "R3";
    if (mem_valid) begin
      exp_v = 1; vtag = "R4";
      exp_bus = mem_bus; exp_dev = mem_dev; exp_fn = mem_fn; exp_reg = mem_reg; exp_w = mem_write;
    end else if (io_valid && io_sel && m_addr[31]) begin
      exp_v = 1; vtag = "R2";
      exp_bus = m_addr[23:16]; exp_dev = m_addr[15:11]; exp_fn = m_addr[10:8];
      exp_reg = m_addr[7:2]; exp_w = io_write;
    end
    if (exp_v) begin
      route_model(exp_bus, exp_dev, exp_fn);
      exp_t1 = exp_oh[2] | exp_oh[4];
    end
    if (io_valid && io_write && !io_sel && io_dword) m_addr = io_wdata & 32'h80FF_FFFC;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(vtag, "route_valid", r_valid, exp_v);
    chk(exp_v ? rtag : "R11", "onehot", r_oh, exp_oh);
    chk(exp_v ? rtag : "R11", "port", r_port, exp_port);
    chk("R11", "type1", r_t1, exp_t1);
    if (exp_v) begin
      chk(vtag, "bus", r_bus, exp_bus);
      chk(vtag, "dev", r_dev, exp_dev);
      chk(vtag, "fn", r_fn, exp_fn);
      chk(vtag, "reg", r_reg, exp_reg);
      chk(vtag, "write", r_write, exp_w);
    end
    chk(rdtag, "rvalid", io_rvalid, exp_rv);
    chk(rdtag, "rdata", io_rdata, exp_rd);
  endtask

  task automatic idle();
    io_valid = 0; mem_valid = 0;
  endtask

  task automatic step();
    model(); tick(); idle();
  endtask

  task automatic io_acc(logic sel, logic wr, logic dw, logic [31:0] d);
    io_valid = 1; io_sel = sel; io_write = wr; io_dword = dw; io_wdata = d;
    step();
  endtask

  task automatic mem_acc(int bus, int dev, int fn, int rg, logic wr);
    mem_valid = 1; mem_bus = 8'(bus); mem_dev = 5'(dev); mem_fn = 3'(fn);
    mem_reg = 6'(rg); mem_write = wr;
    step();
  endtask

  function automatic logic [31:0] caddr(logic en, int bus, int dev, int fn, int rg);
    return {en, 7'h5A, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b11};
  endfunction

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs quiet in reset
    chk("R12", "rst route_valid", r_valid, 0);
    chk("R12", "rst onehot", r_oh, 0);
    chk("R12", "rst rvalid", io_rvalid, 0);
    chk("R12", "rst rdata", io_rdata, 0);
    rst_n = 1;
    step();
    io_acc(0, 0, 0, '0);                       // R12: address register cleared
    port_sec = {8'd20, 8'd10, 8'd5};
    port_sub = {8'd30, 8'd15, 8'd9};
    dev_en = 4'b0101;
    io_acc(0, 1, 1, 32'hFFFF_FFFF);            // R1 masking
    io_acc(0, 0, 0, '0);
    io_acc(0, 1, 0, 32'h0000_1234);            // R1 partial write ignored
    io_acc(0, 0, 0, '0);
    // R5 R6 R7 via indirect path (R2)
    for (int d = 0; d < 7; d++)
      for (int f = 0; f < 3; f++) begin
        io_acc(0, 1, 1, caddr(1, 0, d, f, d + f));
        io_acc(1, 0, 0, '0);
        io_acc(1, 1, 0, '0);
      end
    fn1_en = 1; dev_en = 4'b1010;
    for (int d = 0; d < 7; d++)
      for (int f = 0; f < 3; f++) mem_acc(0, d, f, 7, f[0]);
    // R8 R9 R10 sweep, disjoint ranges
    for (int b = 1; b < 40; b++) mem_acc(b, 3, 1, b, 0);
    // overlapping ranges: equality beats range, lowest index wins
    port_sec = {8'd14, 8'd12, 8'd5};
    port_sub = {8'd25, 8'd15, 8'd40};
    for (int b = 1; b < 45; b++) mem_acc(b, b % 32, b % 8, 63 - b, 1);
    port_sec = {8'd9, 8'd9, 8'd6};             // duplicate secondary
    port_sub = {8'd30, 8'd30, 8'd12};
    for (int b = 5; b < 14; b++) mem_acc(b, 0, 0, 0, 0);
    io_acc(0, 1, 1, caddr(1, 10, 2, 0, 5));
    io_acc(1, 1, 0, '0);                       // R2 write through indirect path
    // R3: disabled data accesses
    io_acc(0, 1, 1, caddr(0, 10, 2, 0, 5));
    io_acc(0, 0, 0, '0);
    io_acc(1, 0, 0, '0);
    io_acc(1, 1, 0, '0);
    // R4: collision with enabled data access
    io_acc(0, 1, 1, caddr(1, 0, 1, 0, 3));
    io_valid = 1; io_sel = 1; io_write = 0; io_dword = 0;
    mem_acc(8, 4, 0, 2, 1);
    io_acc(1, 0, 0, '0);
    mem_acc(0, 2, 0, 1, 0); mem_acc(40, 0, 0, 1, 1); mem_acc(200, 0, 0, 1, 0);
    step(); step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule